// File: doc/BRIEF.md
# Byte/Word Bus Lane Steering

This block connects a 16-bit processor core that issues byte-addressed accesses to a memory organised in 16-bit words. Every access from the core, byte or word, is turned into one aligned word cycle on the memory side. The word address is the byte address with bit 0 dropped, and bit 0 selects the byte lane. A separate byte-cycle input from the core tells the block whether the transfer is one byte or a full word.

On a byte read, the block picks the addressed lane of the returned memory word and places it in the low eight bits of the core data, with the upper bits zero. On a byte write, the byte is copied onto both lanes and only the lane enable picked by address bit 0 is raised. A word access at an odd address is not split into two cycles. It is refused with an alignment error, and no memory cycle is started.

Both sides use a request/ready handshake. The core holds its request until it sees ready. Ready, the read data and the error flag are valid for exactly one cycle.

Top module: `lane_steer`

## Requirements
- R1: While reset is held, and after it is released, `mem_req`, `cpu_ready` and `cpu_err` are 0 until a request arrives.
- R2: `mem_addr` equals `cpu_addr` shifted right by one. Byte addresses 2k and 2k+1 therefore reach the same memory word k, and address 2k+2 reaches word k+1.
- R3: A word read returns the memory word unchanged on `cpu_rdata`.
- R4: A byte read at an even address returns memory bits 7:0 on `cpu_rdata[7:0]`, with `cpu_rdata[15:8]` zero.
- R5: A byte read at an odd address returns memory bits 15:8 on `cpu_rdata[7:0]`, with `cpu_rdata[15:8]` zero.
- R6: A byte access drives `mem_be` = 2'b01 for an even address and 2'b10 for an odd address. A byte write drives `cpu_wdata[7:0]` on both lanes of `mem_wdata`, whatever `cpu_wdata[15:8]` holds.
- R7: A word access drives `mem_be` = 2'b11. A word write passes `cpu_wdata` unchanged to `mem_wdata`. `mem_we` follows `cpu_we`.
- R8: A word access with `cpu_addr[0]` = 1 raises `cpu_err` together with `cpu_ready` in the cycle after acceptance. `mem_req` never rises for it, and memory contents are left unchanged.
- R9: `cpu_ready` rises exactly in the cycle after `mem_ready` is sampled high with `mem_req`, and stays high for one cycle only.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core request, held until `cpu_ready` |
| cpu_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 2*LANE_W | Write data (byte in bits 7:0) |
| cpu_rdata | output | 2*LANE_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Alignment error, valid with `cpu_ready` |
| mem_req | output | 1 | Memory cycle request |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_we | output | 1 | Memory write |
| mem_be | output | 2 | Lane enables, bit 0 = low byte |
| mem_wdata | output | 2*LANE_W | Memory write data |
| mem_rdata | input | 2*LANE_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completion |

## Verification
The latched lane select and byte flag are held inside the block, so an error in them shows up only in data. A wrong lane shows as a misplaced byte, or a nonzero upper half, in the one-cycle read result. On a write it shows as a wrong `mem_be` or `mem_wdata` while `mem_req` is held, which a later word read of the same location then confirms. A state-machine fault shows as `cpu_ready` one cycle early or late relative to `mem_ready`, or as `mem_req` rising on a refused odd word access, so the bench compares the handshake on every clock. Misaligned writes are followed by a read-back of the word to confirm that nothing changed.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RESP = 2'd2
    } lane_state_e;
endpackage

// File: rtl/lane_wr_steer.sv
module lane_wr_steer #(
    parameter int LANE_W = 8
) (
    input  logic                  byte_mode,
    input  logic                  lane_sel,
    input  logic [2*LANE_W-1:0]   data_in,
    output logic [2*LANE_W-1:0]   data_out,
    output logic [1:0]            lane_en
);
    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_comb begin
            data_out[g*LANE_W +: LANE_W] = byte_mode ? data_in[LANE_W-1:0]
                                                     : data_in[g*LANE_W +: LANE_W];
            lane_en[g] = !byte_mode || (lane_sel == 1'(g));
        end
    end
endmodule

// File: rtl/lane_rd_align.sv
module lane_rd_align #(
    parameter int LANE_W = 8
) (
    input  logic                  byte_mode,
    input  logic                  lane_sel,
    input  logic [2*LANE_W-1:0]   word_in,
    output logic [2*LANE_W-1:0]   data_out
);
    logic [LANE_W-1:0] picked;

    always_comb begin
        picked = lane_sel ? word_in[2*LANE_W-1:LANE_W] : word_in[LANE_W-1:0];
        if (byte_mode) begin
            data_out = {{LANE_W{1'b0}}, picked};
        end else begin
            data_out = word_in;
        end
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_byte,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [2*LANE_W-1:0] cpu_wdata,
    output logic [2*LANE_W-1:0] cpu_rdata,
    output logic                cpu_ready,
    output logic                cpu_err,
    output logic                mem_req,
    output logic [ADDR_W-2:0]   mem_addr,
    output logic                mem_we,
    output logic [1:0]          mem_be,
    output logic [2*LANE_W-1:0] mem_wdata,
    input  logic [2*LANE_W-1:0] mem_rdata,
    input  logic                mem_ready
);
    localparam int DATA_W  = 2 * LANE_W;
    localparam int WADDR_W = ADDR_W - 1;

    typedef struct packed {
        lane_state_e         st;
        logic [WADDR_W-1:0]  waddr;
        logic                we;
        logic                byte_mode;
        logic                lane;
        logic [1:0]          be;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                err;
    } lane_regs_t;

    lane_regs_t r_d, r_q;

    logic [DATA_W-1:0] steer_wdata;
    logic [1:0]        steer_be;
    logic [DATA_W-1:0] align_rdata;

    lane_wr_steer #(.LANE_W(LANE_W)) u_wr (
        .byte_mode (cpu_byte),
        .lane_sel  (cpu_addr[0]),
        .data_in   (cpu_wdata),
        .data_out  (steer_wdata),
        .lane_en   (steer_be)
    );

    lane_rd_align #(.LANE_W(LANE_W)) u_rd (
        .byte_mode (r_q.byte_mode),
        .lane_sel  (r_q.lane),
        .word_in   (mem_rdata),
        .data_out  (align_rdata)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.err   = 1'b0;
                r_d.rdata = '0;
                if (cpu_req) begin
                    if (!cpu_byte && cpu_addr[0]) begin
                        r_d.st  = ST_RESP;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st        = ST_MEM;
                        r_d.waddr     = cpu_addr[ADDR_W-1:1];
                        r_d.we        = cpu_we;
                        r_d.byte_mode = cpu_byte;
                        r_d.lane      = cpu_addr[0];
                        r_d.be        = steer_be;
                        r_d.wdata     = steer_wdata;
                    end
                end
            end
            ST_MEM: begin
                if (mem_ready) begin
                    r_d.st    = ST_RESP;
                    r_d.rdata = r_q.we ? '0 : align_rdata;
                end
            end
            ST_RESP: begin
                r_d.st    = ST_IDLE;
                r_d.err   = 1'b0;
                r_d.rdata = '0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = (r_q.st == ST_MEM);
    assign mem_addr  = r_q.waddr;
    assign mem_we    = r_q.we;
    assign mem_be    = r_q.be;
    assign mem_wdata = r_q.wdata;
    assign cpu_ready = (r_q.st == ST_RESP);
    assign cpu_err   = r_q.err;
    assign cpu_rdata = r_q.rdata;
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_ready,
    input logic                cpu_err,
    input logic                mem_req,
    input logic [ADDR_W-2:0]   mem_addr,
    input logic                mem_we,
    input logic [1:0]          mem_be,
    input logic [2*LANE_W-1:0] mem_wdata,
    input logic                mem_ready
);
    a_r8_err_without_mem: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> (cpu_ready && !mem_req));

    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    a_r9_ready_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_err) |-> $past(mem_req && mem_ready));

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    a_r10_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_be) && $stable(mem_wdata)));

    a_r6_lane_enable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_be) != 0));
endmodule

bind lane_steer lane_steer_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/lane_steer_bench.sv
module lane_steer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_byte = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready, cpu_err;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int n_cmp = 0, n_bad = 0;
    int lat = 0, mcnt = 0;
    logic [15:0] mem_arr [int];
    logic [15:0] shadow  [int];

    always #5 clk = ~clk;

    lane_steer u_lane_steer (.*);

    function automatic logic [15:0] init_word(input int a);
        return 16'(a * 40503) ^ 16'h5A5A;
    endfunction

    // memory model: answers after lat extra cycles
    always @(posedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
            mcnt      <= 0;
        end else if (mem_req) begin
            if (mcnt == lat) begin
                logic [15:0] w;
                w = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : init_word(int'(mem_addr));
                mem_ready <= 1'b1;
                mem_rdata <= w;
                if (mem_we) begin
                    if (mem_be[0]) w[7:0]  = mem_wdata[7:0];
                    if (mem_be[1]) w[15:8] = mem_wdata[15:8];
                    mem_arr[int'(mem_addr)] = w;
                end
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic xfer(input logic we, input logic byt, input logic [15:0] addr,
                        input logic [15:0] wd, input int latency);
        logic        mis;
        logic [15:0] word, exp_rd, exp_wd;
        logic [1:0]  exp_be;
        logic        prev_mr, done;
        int          wa;
        mis  = !byt && addr[0];
        wa   = int'(addr[15:1]);
        word = shadow.exists(wa) ? shadow[wa] : init_word(wa);
        if (!byt)        exp_rd = word;
        else if (addr[0]) exp_rd = {8'h00, word[15:8]};
        else              exp_rd = {8'h00, word[7:0]};
        exp_be = !byt ? 2'b11 : (addr[0] ? 2'b10 : 2'b01);
        exp_wd = byt ? {wd[7:0], wd[7:0]} : wd;
        lat = latency;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_byte = byt; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        if (mis) begin
            chk(cpu_ready && cpu_err && !mem_req, "R8 misaligned refused",
                {29'd0, cpu_ready, cpu_err, mem_req}, 32'b110);
            cpu_req = 1'b0;
            @(negedge clk);
            chk(!cpu_ready && !cpu_err && !mem_req, "R9 single pulse", {30'd0, cpu_ready, mem_req}, 32'd0);
            return;
        end
        prev_mr = 1'b0;
        done    = 1'b0;
        for (int n = 0; n < 40; n++) begin
            chk(cpu_ready == prev_mr, "R9 ready timing", {31'd0, cpu_ready}, {31'd0, prev_mr});
            if (cpu_ready) begin
                done = 1'b1;
                break;
            end
            chk(mem_req, "R10 request held", {31'd0, mem_req}, 32'd1);
            chk(mem_addr == addr[15:1], "R2 word address", {17'd0, mem_addr}, {17'd0, addr[15:1]});
            chk(mem_be == exp_be, byt ? "R6 byte lane enable" : "R7 word lane enable",
                {30'd0, mem_be}, {30'd0, exp_be});
            chk(mem_we == we, "R7 write flag", {31'd0, mem_we}, {31'd0, we});
            if (we) chk(mem_wdata == exp_wd, byt ? "R6 byte replicate" : "R7 word data",
                        {16'd0, mem_wdata}, {16'd0, exp_wd});
            prev_mr = mem_ready;
            @(negedge clk);
        end
        if (!done) begin
            chk(1'b0, "R9 watchdog no ready", 32'd0, 32'd1);
            return;
        end
        chk(!cpu_err, "R8 no error on aligned", {31'd0, cpu_err}, 32'd0);
        if (!we) begin
            chk(cpu_rdata == exp_rd, !byt ? "R3 word read" : (addr[0] ? "R5 odd byte read" : "R4 even byte read"),
                {16'd0, cpu_rdata}, {16'd0, exp_rd});
        end else begin
            if (byt && addr[0])  word[15:8] = wd[7:0];
            else if (byt)        word[7:0]  = wd[7:0];
            else                 word       = wd;
            shadow[wa] = word;
        end
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_ready, "R9 single pulse", {31'd0, cpu_ready}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_req && !cpu_ready && !cpu_err, "R1 in reset", {29'd0, mem_req, cpu_ready, cpu_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && !cpu_ready && !cpu_err, "R1 after reset", {29'd0, mem_req, cpu_ready, cpu_err}, 32'd0);

        xfer(1, 0, 16'h0100, 16'hA55A, 1);   // R7 word write
        xfer(0, 0, 16'h0100, 16'h0000, 0);   // R3
        xfer(1, 1, 16'h0100, 16'hEE3C, 2);   // R6 even byte, upper garbage
        xfer(1, 1, 16'h0101, 16'h11C3, 0);   // R6 odd byte
        xfer(0, 0, 16'h0100, 16'h0000, 1);   // R3 merged word
        xfer(0, 1, 16'h0101, 16'h0000, 0);   // R5
        xfer(0, 1, 16'h0100, 16'h0000, 3);   // R4
        xfer(0, 1, 16'h0203, 16'h0000, 1);   // R5 untouched word
        xfer(0, 1, 16'h0202, 16'h0000, 0);   // R4 untouched word
        xfer(0, 0, 16'h0202, 16'h0000, 2);   // R2 same word as 0x0203
        xfer(0, 0, 16'h0204, 16'h0000, 0);   // R2 next word
        xfer(1, 0, 16'h0101, 16'hFFFF, 0);   // R8 misaligned write
        xfer(0, 0, 16'h0100, 16'h0000, 0);   // R8 memory unchanged
        xfer(0, 0, 16'h0303, 16'h0000, 0);   // R8 misaligned read
        xfer(1, 1, 16'h0301, 16'hEE77, 1);   // R6
        xfer(0, 0, 16'h0300, 16'h0000, 0);   // R3
        for (int i = 0; i < 8; i++) begin
            xfer(1, 0, 16'(16'h0400 + 2 * i), 16'(16'h1234 * (i + 1)), i % 4);
            xfer(0, 1, 16'(16'h0400 + 2 * i + (i % 2)), 16'h0000, (i + 1) % 4);
            xfer(0, 0, 16'(16'h0400 + 2 * i), 16'h0000, (i + 2) % 4);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule